// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front End

This block is the processor-facing side of a 16550-style serial port. A bus master reaches eight word-aligned 32-bit registers through a simple request interface. The block keeps one received byte and the line status flags, passes transmit bytes on as a one-cycle strobe, and presents the line, modem and divisor settings to the bit-level serializer. The serializer, the deserializer and the baud generator sit outside the block. The modem status byte is taken as an input that is already synchronised.

There is no receive FIFO. The deserializer offers a byte with a valid strobe, together with its parity, framing and break indications. The block latches the byte in a single holding register. If a byte arrives before software has read the previous one, the block records an overrun. A single level interrupt output and an identification code are recomputed from a fixed four-level priority in the edge that ends each bus access or receive event. Each is held between such events.

Top module: `serial_csr_core`

## Requirements
- R1: After reset, irq is low, rx_ready is high, and err_pulse and tx_strobe are low. Line status (word offset 5) reads 0x60 and identification (offset 2) reads 0x1. Every configuration output is zero. Bits 5 and 6 of line status, the transmit-idle flags, always read as 1.
- R2: Writes to offsets 1, 3, 4 and 7 are stored. Offset 1 is interrupt enable, and only its bits 3:0 are kept. Offset 3 drives line_ctrl, offset 4 drives modem_ctrl and offset 7 drives divisor, from the cycle after the write. A read of any of these four offsets returns zero.
- R3: Offsets 2, 5 and 6 are read-only, and a write to them changes nothing. Offset 6 returns msr_in in bits 7:0.
- R4: A receive strobe (rx_valid) latches rx_data and sets data ready (line status bit 0). rx_ready is the inverse of data ready.
- R5: A read of offset 0 returns the held byte and clears data ready, unless a new byte arrives in the same cycle.
- R6: A byte that arrives while data ready is set, with no read of offset 0 in the same cycle, sets overrun (bit 1) and replaces the held byte. rx_perr, rx_ferr and rx_brk set bits 2, 3 and 4. All four error flags stay set until reset.
- R7: A write to offset 0 raises tx_strobe for exactly one cycle, in the cycle after the write, with tx_byte set to the low 8 write bits. No stored register changes.
- R8: Interrupt enable bits are: bit 0 data ready, bit 1 transmit holding empty, bit 2 line errors, bit 3 modem status. The identification code is chosen in priority order: any error flag with bit 2 enabled gives 3'b110; data ready with bit 0 gives 3'b100; transmit holding empty with bit 1 gives 3'b010; msr_in[3:0] nonzero with bit 3 gives 3'b000. Any of these drives irq high.
- R9: When no enabled cause is active, irq is low and the identification code is 3'b001.
- R10: irq and the identification code are registered. They update only at an edge with a bus request or a receive strobe, and they do not follow msr_in changes while the block is idle.
- R11: An access to an offset above 7, a misaligned access, a read of a write-only offset or a write to a read-only offset is invalid. It makes err_pulse high for exactly the next cycle. An out-of-range or misaligned access reads zero and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, combinational while a read is requested, else zero |
| err_pulse | output | 1 | One-cycle flag for an invalid access |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | BYTE_W | Received byte |
| rx_perr | input | 1 | Parity error with the strobe |
| rx_ferr | input | 1 | Framing error with the strobe |
| rx_brk | input | 1 | Break with the strobe |
| rx_ready | output | 1 | Holding register empty |
| tx_strobe | output | 1 | Transmit byte strobe |
| tx_byte | output | BYTE_W | Transmit byte |
| msr_in | input | 8 | Modem status byte |
| line_ctrl | output | DATA_W | Line control setting |
| modem_ctrl | output | DATA_W | Modem control setting |
| divisor | output | DATA_W | Baud divisor setting |
| irq | output | 1 | Level interrupt |

## Verification
The interrupt path is driven through every enable mask with causes stacked one at a time: modem alone, then transmit empty, then data ready, then an overrun. Each step shows that the higher cause hides the lower one, and clearing the mask shows the idle code. The receive path gets a single byte, a byte pair that overruns, and bytes that carry error flags. These separate latching, sticky flags and clearing on read. A change of msr_in while the bus is idle separates a registered interrupt from a combinational one. Out-of-range, misaligned and wrong-direction accesses show that err_pulse fires and that the settings are left untouched.

// File: rtl/serial_csr_pkg.sv
// Shared constants and types for the serial register front end.
// Assumes eight word registers. The offsets are fixed because software decodes them.
package serial_csr_pkg;

    localparam int NUM_REGS = 8;
    localparam int MSR_W    = 8;
    localparam int IEN_W    = 4;

    // Word offsets of the registers
    localparam int OFS_DATA  = 0;
    localparam int OFS_IEN   = 1;
    localparam int OFS_IID   = 2;
    localparam int OFS_LCTL  = 3;
    localparam int OFS_MCTL  = 4;
    localparam int OFS_LSTAT = 5;
    localparam int OFS_MSTAT = 6;
    localparam int OFS_DIVR  = 7;

    // Access permissions, one bit per offset
    localparam logic [NUM_REGS-1:0] RD_MASK = 8'b0110_0101;
    localparam logic [NUM_REGS-1:0] WR_MASK = 8'b1001_1011;

    // Interrupt enable bit positions
    localparam int IEN_RXD  = 0;
    localparam int IEN_THE  = 1;
    localparam int IEN_LINE = 2;
    localparam int IEN_MDM  = 3;

    // Identification codes
    localparam logic [2:0] IID_LINE = 3'b110;
    localparam logic [2:0] IID_RXD  = 3'b100;
    localparam logic [2:0] IID_THE  = 3'b010;
    localparam logic [2:0] IID_MDM  = 3'b000;
    localparam logic [2:0] IID_NONE = 3'b001;

    // Receive-side line status flags, data ready in bit 0
    typedef struct packed {
        logic brk;
        logic ferr;
        logic perr;
        logic ovr;
        logic dr;
    } rx_flags_t;

endpackage

// File: rtl/serial_csr_decode.sv
// Address decoder: turns a bus request into per-register read and write
// selects that respect the access permissions. It also flags an invalid access.
// Assumes ADDR_W >= 5, so that the word offset has at least 3 bits.
module serial_csr_decode
    import serial_csr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic [NUM_REGS-1:0] sel_rd,
    output logic [NUM_REGS-1:0] sel_wr,
    output logic                bad_access
);

    localparam int OFS_W = ADDR_W - 2;

    logic [OFS_W-1:0]    ofs;
    logic                in_range;
    logic                aligned;
    logic [NUM_REGS-1:0] hit;

    assign ofs     = req_addr[ADDR_W-1:2];
    assign aligned = (req_addr[1:0] == 2'b00);

    // Range check: the upper offset bits must be zero when they exist
    generate
        if (OFS_W > 3) begin : g_wide
            assign in_range = ~|ofs[OFS_W-1:3];
        end else begin : g_narrow
            assign in_range = 1'b1;
        end
    endgenerate

    // One-hot hit vector, gated with request validity
    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
            assign hit[g]    = req_valid & in_range & aligned & (ofs[2:0] == 3'(g));
            assign sel_rd[g] = hit[g] & ~req_write & RD_MASK[g];
            assign sel_wr[g] = hit[g] &  req_write & WR_MASK[g];
        end
    endgenerate

    // Invalid: outside the map, misaligned, or wrong direction
    always_comb begin
        bad_access = 1'b0;
        if (req_valid) begin
            if (!in_range || !aligned)
                bad_access = 1'b1;
            else if (req_write)
                bad_access = |(hit & ~WR_MASK);
            else
                bad_access = |(hit & ~RD_MASK);
        end
    end

endmodule

// File: rtl/serial_csr_rxhold.sv
// Single-byte receive holding register with line status flags.
// A byte is always accepted. Overrun is recorded when unread data is replaced.
// The error flags are sticky until reset. Next-state values are exported so
// that the interrupt logic can evaluate the state after the current event.
module serial_csr_rxhold
    import serial_csr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_brk,
    input  logic              data_rd,
    output logic [BYTE_W-1:0] byte_q,
    output rx_flags_t         flags_q,
    output rx_flags_t         flags_n
);

    logic [BYTE_W-1:0] byte_n;

    // Next-state: a read frees the holder, a new byte fills it
    always_comb begin
        flags_n = flags_q;
        byte_n  = byte_q;
        if (data_rd)
            flags_n.dr = 1'b0;
        if (rx_valid) begin
            if (flags_q.dr && !data_rd)
                flags_n.ovr = 1'b1;
            flags_n.dr   = 1'b1;
            flags_n.perr = flags_q.perr | rx_perr;
            flags_n.ferr = flags_q.ferr | rx_ferr;
            flags_n.brk  = flags_q.brk  | rx_brk;
            byte_n       = rx_data;
        end
    end

    // State register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            byte_q  <= '0;
        end else begin
            flags_q <= flags_n;
            byte_q  <= byte_n;
        end
    end

endmodule

// File: rtl/serial_csr_irqsel.sv
// Interrupt prioritiser: picks the highest enabled cause and registers the
// level output and the identification code. It updates only when eval is high.
// Assumes its inputs already show the state after the current event.
module serial_csr_irqsel
    import serial_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eval,
    input  logic [IEN_W-1:0] ien,
    input  rx_flags_t        flags,
    input  logic             thr_empty,
    input  logic [3:0]       msr_delta,
    output logic             irq,
    output logic [2:0]       iid
);

    logic       irq_n;
    logic [2:0] iid_n;
    logic       line_err;

    assign line_err = flags.ovr | flags.perr | flags.ferr | flags.brk;

    // Fixed four-level priority encoder
    always_comb begin
        irq_n = 1'b1;
        if (line_err && ien[IEN_LINE])
            iid_n = IID_LINE;
        else if (flags.dr && ien[IEN_RXD])
            iid_n = IID_RXD;
        else if (thr_empty && ien[IEN_THE])
            iid_n = IID_THE;
        else if ((|msr_delta) && ien[IEN_MDM])
            iid_n = IID_MDM;
        else begin
            irq_n = 1'b0;
            iid_n = IID_NONE;
        end
    end

    // Output registers, refreshed on access or receive events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
            iid <= IID_NONE;
        end else if (eval) begin
            irq <= irq_n;
            iid <= iid_n;
        end
    end

endmodule

// File: rtl/serial_csr_core.sv
// Top of the serial register front end. It stores the configuration
// registers, builds the read data, emits the transmit strobe and the error
// pulse, and connects the decoder, the receive holder and the prioritiser.
// Assumes DATA_W >= 8, BYTE_W <= DATA_W and ADDR_W >= 5. The transmitter is
// outside the block, so the holding-empty flags read as constant 1.
module serial_csr_core
    import serial_csr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              err_pulse,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_brk,
    output logic              rx_ready,
    output logic              tx_strobe,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic [MSR_W-1:0]  msr_in,
    output logic [DATA_W-1:0] line_ctrl,
    output logic [DATA_W-1:0] modem_ctrl,
    output logic [DATA_W-1:0] divisor,
    output logic              irq
);

    localparam int NUM_CFG = 3;
    localparam int CFG_OFS [NUM_CFG] = '{OFS_LCTL, OFS_MCTL, OFS_DIVR};

    logic [NUM_REGS-1:0] sel_rd;
    logic [NUM_REGS-1:0] sel_wr;
    logic                bad_acc;
    logic                data_rd;
    logic [BYTE_W-1:0]   byte_q;
    rx_flags_t           flags_q;
    rx_flags_t           flags_n;
    logic [IEN_W-1:0]    ien_q;
    logic [DATA_W-1:0]   cfg_q [NUM_CFG];
    logic [2:0]          iid_w;
    logic                tx_strobe_q;
    logic [BYTE_W-1:0]   tx_byte_q;
    logic                err_q;

    serial_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .sel_rd     (sel_rd),
        .sel_wr     (sel_wr),
        .bad_access (bad_acc)
    );

    assign data_rd = sel_rd[OFS_DATA];

    serial_csr_rxhold #(.BYTE_W(BYTE_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_valid(rx_valid),
        .rx_data (rx_data),
        .rx_perr (rx_perr),
        .rx_ferr (rx_ferr),
        .rx_brk  (rx_brk),
        .data_rd (data_rd),
        .byte_q  (byte_q),
        .flags_q (flags_q),
        .flags_n (flags_n)
    );

    assign rx_ready = ~flags_q.dr;

    // Interrupt enable register, low bits only
    always_ff @(posedge clk) begin
        if (!rst_n)
            ien_q <= '0;
        else if (sel_wr[OFS_IEN])
            ien_q <= req_wdata[IEN_W-1:0];
    end

    // Full-width configuration registers, one per write-only offset
    generate
        for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cfg_q[g] <= '0;
                else if (sel_wr[CFG_OFS[g]])
                    cfg_q[g] <= req_wdata;
            end
        end
    endgenerate

    assign line_ctrl  = cfg_q[0];
    assign modem_ctrl = cfg_q[1];
    assign divisor    = cfg_q[2];

    serial_csr_irqsel u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .eval     (req_valid | rx_valid),
        .ien      (sel_wr[OFS_IEN] ? req_wdata[IEN_W-1:0] : ien_q),
        .flags    (flags_n),
        .thr_empty(1'b1),
        .msr_delta(msr_in[3:0]),
        .irq      (irq),
        .iid      (iid_w)
    );

    // Read data multiplexer; zero when nothing readable is selected
    always_comb begin
        rd_data = '0;
        if (sel_rd[OFS_DATA])
            rd_data[BYTE_W-1:0] = byte_q;
        if (sel_rd[OFS_IID])
            rd_data[2:0] = iid_w;
        if (sel_rd[OFS_LSTAT])
            rd_data[6:0] = {2'b11, flags_q};
        if (sel_rd[OFS_MSTAT])
            rd_data[MSR_W-1:0] = msr_in;
    end

    // Transmit strobe and invalid-access pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_strobe_q <= 1'b0;
            tx_byte_q   <= '0;
            err_q       <= 1'b0;
        end else begin
            tx_strobe_q <= sel_wr[OFS_DATA];
            if (sel_wr[OFS_DATA])
                tx_byte_q <= req_wdata[BYTE_W-1:0];
            err_q <= bad_acc;
        end
    end

    assign tx_strobe = tx_strobe_q;
    assign tx_byte   = tx_byte_q;
    assign err_pulse = err_q;

endmodule

// File: rtl/serial_csr_chk.sv
// Property checker for serial_csr_core, attached with bind below.
// It watches the bus, the receive strobe and the registered outputs.
module serial_csr_chk #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic [DATA_W-1:0] rd_data,
    input logic              err_pulse,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_strobe,
    input logic [BYTE_W-1:0] tx_byte,
    input logic              irq,
    input logic [2:0]        iid,
    input logic              ovr
);

    logic       aligned_in;
    logic [2:0] ofs3;
    logic       data_read;
    logic       data_write;
    logic       wo_read;

    assign aligned_in = ((req_addr >> 5) == 0) && (req_addr[1:0] == 2'b00);
    assign ofs3       = req_addr[4:2];
    assign data_read  = req_valid && !req_write && aligned_in && ofs3 == 3'd0;
    assign data_write = req_valid &&  req_write && aligned_in && ofs3 == 3'd0;
    assign wo_read    = req_valid && !req_write && aligned_in &&
                        (ofs3 == 3'd1 || ofs3 == 3'd3 || ofs3 == 3'd4 || ofs3 == 3'd7);

    // R2: write-only offsets read as zero
    p_wo_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wo_read |-> rd_data == '0);

    // R4: a received byte occupies the holder
    p_rx_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !data_read |=> !rx_ready);

    // R5: reading data with no new byte frees the holder
    p_rd_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_read && !rx_valid |=> rx_ready);

    // R6: byte over unread data records overrun
    p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !rx_ready && !data_read |=> ovr);

    // R7: data write gives a strobe with the written byte
    p_tx_emit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        data_write |=> tx_strobe && tx_byte == $past(req_wdata[BYTE_W-1:0]));

    // R7: no strobe without a data write
    p_tx_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !data_write |=> !tx_strobe);

    // R8: a raised interrupt never carries the idle code
    p_active_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !iid[0]);

    // R9: no interrupt means the idle code
    p_idle_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> iid == 3'b001);

    // R10: without events the interrupt state holds
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid && !rx_valid |=> $stable(irq) && $stable(iid));

    // R11: out-of-range or misaligned access pulses the error flag and reads zero
    p_bad_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !aligned_in |=> err_pulse);

    p_bad_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write && !aligned_in |-> rd_data == '0);

    // R11: the error flag lasts one cycle unless the access repeats
    p_err_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !err_pulse);

endmodule

bind serial_csr_core serial_csr_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .BYTE_W(BYTE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rd_data  (rd_data),
    .err_pulse(err_pulse),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .tx_strobe(tx_strobe),
    .tx_byte  (tx_byte),
    .irq      (irq),
    .iid      (iid_w),
    .ovr      (flags_q.ovr)
);

// File: tb/sim_serial_csr_core.sv
// Directed bench for serial_csr_core. There is one task per scenario.
// Inputs change on the falling edge, and results are sampled there or 1 ns later.
module sim_serial_csr_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic        err_pulse;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_perr = 1'b0;
    logic        rx_ferr = 1'b0;
    logic        rx_brk = 1'b0;
    logic        rx_ready;
    logic        tx_strobe;
    logic [7:0]  tx_byte;
    logic [7:0]  msr_in = '0;
    logic [31:0] line_ctrl;
    logic [31:0] modem_ctrl;
    logic [31:0] divisor;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    serial_csr_core u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_data(rd_data), .err_pulse(err_pulse),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rx_ready(rx_ready),
        .tx_strobe(tx_strobe), .tx_byte(tx_byte), .msr_in(msr_in),
        .line_ctrl(line_ctrl), .modem_ctrl(modem_ctrl), .divisor(divisor),
        .irq(irq)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        msr_in = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic rd_raw(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        #1 v = rd_data;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wr_raw(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd_reg(input int ofs, output logic [31:0] v);
        rd_raw(6'(ofs * 4), v);
    endtask

    task automatic wr_reg(input int ofs, input logic [31:0] d);
        wr_raw(6'(ofs * 4), d);
    endtask

    task automatic rx_push(input logic [7:0] b, input logic pe, input logic fe, input logic bk);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b; rx_perr = pe; rx_ferr = fe; rx_brk = bk;
        @(negedge clk);
        rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq after reset", 32'(irq), 32'h0);
        chk("R1 rx_ready after reset", 32'(rx_ready), 32'h1);
        chk("R1 err_pulse after reset", 32'(err_pulse), 32'h0);
        chk("R1 tx_strobe after reset", 32'(tx_strobe), 32'h0);
        chk("R1 line_ctrl after reset", line_ctrl, 32'h0);
        chk("R1 divisor after reset", divisor, 32'h0);
        rd_reg(5, v);
        chk("R1 line status after reset", v, 32'h60);
        rd_reg(2, v);
        chk("R1 identification after reset", v, 32'h1);
    endtask

    task automatic t_cfg();
        logic [31:0] v;
        wr_reg(3, 32'h0000_001b);
        wr_reg(4, 32'h0000_0003);
        wr_reg(7, 32'hCAFE_1234);
        chk("R2 line_ctrl", line_ctrl, 32'h1b);
        chk("R2 modem_ctrl", modem_ctrl, 32'h3);
        chk("R2 divisor", divisor, 32'hCAFE_1234);
        rd_reg(3, v);
        chk("R2 line control reads zero", v, 32'h0);
        chk("R11 error on write-only read", 32'(err_pulse), 32'h1);
        @(negedge clk);
        chk("R11 error lasts one cycle", 32'(err_pulse), 32'h0);
        rd_reg(7, v);
        chk("R2 divisor reads zero", v, 32'h0);
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        msr_in = 8'hA2;
        wr_reg(5, 32'h0);
        chk("R11 error on read-only write", 32'(err_pulse), 32'h1);
        rd_reg(5, v);
        chk("R3 line status unchanged by write", v, 32'h60);
        wr_reg(2, 32'hFF);
        rd_reg(2, v);
        chk("R3 identification unchanged by write", v, 32'h1);
        wr_reg(6, 32'h0);
        rd_reg(6, v);
        chk("R3 modem status follows input", v, 32'hA2);
    endtask

    task automatic t_rx();
        logic [31:0] v;
        do_reset();
        rx_push(8'hA5, 1'b0, 1'b0, 1'b0);
        chk("R4 rx_ready low with data", 32'(rx_ready), 32'h0);
        rd_reg(5, v);
        chk("R4 data ready set", v, 32'h61);
        rd_reg(0, v);
        chk("R5 held byte", v, 32'hA5);
        chk("R5 rx_ready after read", 32'(rx_ready), 32'h1);
        rd_reg(5, v);
        chk("R5 data ready cleared", v, 32'h60);
    endtask

    task automatic t_overrun();
        logic [31:0] v;
        do_reset();
        rx_push(8'h11, 1'b0, 1'b0, 1'b0);
        rx_push(8'h22, 1'b0, 1'b0, 1'b0);
        rd_reg(5, v);
        chk("R6 overrun flagged", v, 32'h63);
        rd_reg(0, v);
        chk("R6 newest byte kept", v, 32'h22);
        rd_reg(5, v);
        chk("R6 overrun sticky", v, 32'h62);
        do_reset();
        rx_push(8'h33, 1'b1, 1'b0, 1'b1);
        rd_reg(5, v);
        chk("R6 parity and break flags", v, 32'h75);
        rx_push(8'h44, 1'b0, 1'b1, 1'b0);
        rd_reg(5, v);
        chk("R6 framing plus overrun", v, 32'h7F);
    endtask

    task automatic t_tx();
        logic [31:0] v;
        do_reset();
        wr_reg(0, 32'h0000_01C3);
        chk("R7 strobe high", 32'(tx_strobe), 32'h1);
        chk("R7 strobe byte", 32'(tx_byte), 32'hC3);
        @(negedge clk);
        chk("R7 strobe one cycle", 32'(tx_strobe), 32'h0);
        rd_reg(5, v);
        chk("R7 line status untouched", v, 32'h60);
        rd_reg(0, v);
        chk("R7 holder untouched", v, 32'h0);
    endtask

    task automatic t_prio();
        logic [31:0] v;
        do_reset();
        msr_in = 8'h01;
        wr_reg(1, 32'h08);
        chk("R8 modem irq", 32'(irq), 32'h1);
        rd_reg(2, v);
        chk("R8 modem code", v, 32'h0);
        wr_reg(1, 32'h0A);
        rd_reg(2, v);
        chk("R8 transmit empty beats modem", v, 32'h2);
        rx_push(8'h44, 1'b0, 1'b0, 1'b0);
        wr_reg(1, 32'h0B);
        rd_reg(2, v);
        chk("R8 data ready beats transmit", v, 32'h4);
        rx_push(8'h55, 1'b0, 1'b0, 1'b0);
        wr_reg(1, 32'h0F);
        chk("R8 line irq", 32'(irq), 32'h1);
        rd_reg(2, v);
        chk("R8 line error beats data", v, 32'h6);
        wr_reg(1, 32'h00);
        chk("R9 irq low with no enables", 32'(irq), 32'h0);
        rd_reg(2, v);
        chk("R9 idle code", v, 32'h1);
    endtask

    task automatic t_hold();
        logic [31:0] v;
        do_reset();
        wr_reg(1, 32'h08);
        chk("R9 no modem change no irq", 32'(irq), 32'h0);
        msr_in = 8'h02;
        repeat (3) @(negedge clk);
        chk("R10 irq waits for an event", 32'(irq), 32'h0);
        rd_reg(5, v);
        chk("R10 irq after access", 32'(irq), 32'h1);
        rd_reg(2, v);
        chk("R10 modem code after access", v, 32'h0);
    endtask

    task automatic t_bad();
        logic [31:0] v;
        do_reset();
        wr_reg(3, 32'h5A);
        rd_raw(6'h24, v);
        chk("R11 out-of-range reads zero", v, 32'h0);
        chk("R11 out-of-range error", 32'(err_pulse), 32'h1);
        @(negedge clk);
        chk("R11 error one cycle", 32'(err_pulse), 32'h0);
        wr_raw(6'h30, 32'hFFFF_FFFF);
        chk("R11 out-of-range write error", 32'(err_pulse), 32'h1);
        chk("R11 out-of-range write ignored", line_ctrl, 32'h5A);
        chk("R11 divisor untouched", divisor, 32'h0);
        wr_raw(6'h0D, 32'h77);
        chk("R11 misaligned error", 32'(err_pulse), 32'h1);
        chk("R11 misaligned write ignored", line_ctrl, 32'h5A);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Scenario sequence
    initial begin
        do_reset();
        t_reset();
        t_cfg();
        t_readonly();
        t_rx();
        t_overrun();
        t_tx();
        t_prio();
        t_hold();
        t_bad();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule